// File: doc/BRIEF.md
# Conversion Result and Status Register Bank

This block holds the most recent conversion result of every analog channel of a multi-channel successive-approximation converter. It exposes the results to a host through a byte-wide register-read port, which a serial host interface drives with a read strobe and a register address. The conversion sequencer hands over each finished result as a channel number, a code and a flag that gives the resolution of that result (10-bit or 8-bit). An 8-bit result arrives in the low eight code bits.

The host picks one of two register layouts with a mode input. In the 10-bit layout every channel owns a pair of byte registers: a high register with the two top code bits, and a low register with the eight bottom bits. In the 8-bit layout every channel owns one byte register, so a single read returns its result. A status register sits at one fixed address in both layouts. It carries one completion flag per channel. Together with an interrupt enable input, those flags drive a level interrupt output, so the host can wait for results without polling.

A high-byte read captures the matching low byte. The following low-byte read of that channel therefore returns half of the same result, even if the sequencer has replaced the result in between. A result that arrives in the same cycle as a read of its channel takes effect after that read.

Top module: `adc_result_bank`

## Requirements
- R1: While reset is asserted and right after it, rd_data_o is 0x00, rd_valid_o is 0, irq_o is 0 and the status register reads 0x00.
- R2: A read strobed on a clock edge presents its byte on rd_data_o, with rd_valid_o high, after that same edge. rd_valid_o is low after every edge without a strobe.
- R3: In the 10-bit layout (ten_mode_i=1), address 2c reads {6'b0, code[9:8]} of channel c and address 2c+1 reads code[7:0] of channel c.
- R4: In the 8-bit layout (ten_mode_i=0), address c reads channel c. A result stored as 8-bit returns its 8-bit code. A result stored as 10-bit returns code[9:2].
- R5: A result written with wr_ten_i=0 keeps only wr_code_i[7:0], and wr_code_i[9:8] is ignored. In the 10-bit layout its high register reads 0x00 and its low register reads the 8-bit code.
- R6: Address 2*NUM_CH (16) is the status register in both layouts. Bit c is the done flag of channel c. Reading the status register changes no flag.
- R7: A result write sets the done flag of its channel. That flag is cleared by reading the channel's low register (10-bit layout) or its single register (8-bit layout). A high-register read leaves it set.
- R8: When a result write and a flag-clearing read of the same channel share a clock edge, the read returns the previous result and the done flag ends up set.
- R9: A high-register read stores the channel's low byte. The next low-register read of that channel returns the stored byte, even if a new result was written in between. The stored byte is used only once.
- R10: irq_o is high exactly when irq_en_i is high and at least one done flag is set.
- R11: Addresses that map to nothing in the current layout (8 to 15 in the 8-bit layout, and above 16 in either layout) read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ten_mode_i | input | 1 | Register layout: 1 = two registers per channel, 0 = one register per channel |
| irq_en_i | input | 1 | Interrupt enable |
| wr_valid_i | input | 1 | Sequencer result strobe |
| wr_ch_i | input | 3 | Channel of the delivered result |
| wr_code_i | input | 10 | Result code (8-bit results in bits 7:0) |
| wr_ten_i | input | 1 | Resolution of the delivered result: 1 = 10-bit, 0 = 8-bit |
| rd_en_i | input | 1 | Host read strobe |
| rd_addr_i | input | 5 | Host register address |
| rd_data_o | output | 8 | Read data, registered |
| rd_valid_o | output | 1 | Read data valid, one cycle after the strobe |
| irq_o | output | 1 | Level interrupt request |

## Verification
The bench first writes a mix of 10-bit and 8-bit results. It then walks every address in both layouts, so a design that placed the two high bits in the wrong register, or kept more than two bits there, returns wrong bytes. A design that gave back the low byte of a 10-bit result in the 8-bit layout also returns wrong bytes. The bench strobes a write on the same edge as a low-register read of that channel. A design that let the write win would return the new byte, and a design that let the clear win would lose the done flag. A result that changes between a high read and a low read catches a design without the capture register, because that design hands out a torn pair. Status reads repeated with the interrupt enable toggled expose flags that a status read clears and interrupts that do not follow the enable.

// File: rtl/adc_rb_pkg.sv
package adc_rb_pkg;

    // Register kind selected by a host address
    typedef enum logic [2:0] {
        SEL_NONE = 3'd0,
        SEL_HI   = 3'd1,
        SEL_LO   = 3'd2,
        SEL_BYTE = 3'd3,
        SEL_STAT = 3'd4
    } sel_kind_e;

endpackage

// File: rtl/rb_addr_decode.sv
module rb_addr_decode
    import adc_rb_pkg::*;
#(
    parameter int NUM_CH = 8,
    parameter int CH_W   = 3,
    parameter int ADDR_W = 5
) (
    input  logic              ten_mode_i,
    input  logic [ADDR_W-1:0] addr_i,
    output sel_kind_e         kind_o,
    output logic [CH_W-1:0]   ch_o
);

    localparam int STAT_ADDR = 2 * NUM_CH;

    always_comb begin
        kind_o = SEL_NONE;
        ch_o   = '0;
        if (addr_i == ADDR_W'(STAT_ADDR)) begin
            kind_o = SEL_STAT;
        end else if (ten_mode_i) begin
            if (addr_i < ADDR_W'(STAT_ADDR)) begin
                kind_o = addr_i[0] ? SEL_LO : SEL_HI;
                ch_o   = addr_i[CH_W:1];
            end
        end else begin
            if (addr_i < ADDR_W'(NUM_CH)) begin
                kind_o = SEL_BYTE;
                ch_o   = addr_i[CH_W-1:0];
            end
        end
    end

endmodule

// File: rtl/rb_result_store.sv
module rb_result_store #(
    parameter int NUM_CH = 8,
    parameter int CH_W   = 3,
    parameter int RES_W  = 10,
    parameter int BYTE_W = 8
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_valid_i,
    input  logic [CH_W-1:0]                wr_ch_i,
    input  logic [RES_W-1:0]               wr_code_i,
    input  logic                           wr_ten_i,
    input  logic                           clr_i,
    input  logic [CH_W-1:0]                clr_ch_i,
    output logic [NUM_CH-1:0][RES_W-1:0]   code_o,
    output logic [NUM_CH-1:0]              ten_o,
    output logic [NUM_CH-1:0]              done_o
);

    typedef struct packed {
        logic [NUM_CH-1:0][RES_W-1:0] code;
        logic [NUM_CH-1:0]            ten;
        logic [NUM_CH-1:0]            done;
    } store_t;

    store_t s_d, s_q;
    logic [RES_W-1:0] norm_code;

    always_comb begin
        // 8-bit results keep only their low byte
        norm_code = wr_ten_i ? wr_code_i : RES_W'(wr_code_i[BYTE_W-1:0]);
        s_d = s_q;
        if (clr_i) begin
            s_d.done[clr_ch_i] = 1'b0;
        end
        // a new result overrides a clear in the same cycle
        if (wr_valid_i) begin
            s_d.code[wr_ch_i] = norm_code;
            s_d.ten[wr_ch_i]  = wr_ten_i;
            s_d.done[wr_ch_i] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign code_o = s_q.code;
    assign ten_o  = s_q.ten;
    assign done_o = s_q.done;

    assert_done_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid_i |=> done_o[$past(wr_ch_i)]);

    assert_done_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !(wr_valid_i && wr_ch_i == clr_ch_i)) |=> !done_o[$past(clr_ch_i)]);

    assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && wr_valid_i && wr_ch_i == clr_ch_i) |=> done_o[$past(clr_ch_i)]);

    assert_code_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_valid_i |=> $stable(code_o));

endmodule

// File: rtl/rb_readout.sv
module rb_readout
    import adc_rb_pkg::*;
#(
    parameter int NUM_CH = 8,
    parameter int CH_W   = 3,
    parameter int RES_W  = 10,
    parameter int BYTE_W = 8
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           rd_en_i,
    input  sel_kind_e                      kind_i,
    input  logic [CH_W-1:0]                ch_i,
    input  logic [NUM_CH-1:0][RES_W-1:0]   code_i,
    input  logic [NUM_CH-1:0]              ten_i,
    input  logic [NUM_CH-1:0]              done_i,
    output logic [BYTE_W-1:0]              rd_data_o,
    output logic                           rd_valid_o
);

    localparam int HI_W = RES_W - BYTE_W;

    typedef struct packed {
        logic [BYTE_W-1:0] data;
        logic              valid;
        sel_kind_e         kind;
        logic [BYTE_W-1:0] hold_lo;
        logic [CH_W-1:0]   hold_ch;
        logic              hold_vld;
    } rd_t;

    rd_t r_d, r_q;
    logic [RES_W-1:0]  sel_code;
    logic [BYTE_W-1:0] hi_byte, lo_byte, top_byte;

    always_comb begin
        sel_code = code_i[ch_i];
        hi_byte  = BYTE_W'(sel_code[RES_W-1:BYTE_W]);
        lo_byte  = sel_code[BYTE_W-1:0];
        top_byte = sel_code[RES_W-1:HI_W];

        r_d       = r_q;
        r_d.valid = rd_en_i;
        r_d.kind  = rd_en_i ? kind_i : SEL_NONE;
        if (rd_en_i) begin
            case (kind_i)
                SEL_HI: begin
                    r_d.data     = hi_byte;
                    r_d.hold_lo  = lo_byte;
                    r_d.hold_ch  = ch_i;
                    r_d.hold_vld = 1'b1;
                end
                SEL_LO: begin
                    if (r_q.hold_vld && r_q.hold_ch == ch_i) begin
                        r_d.data     = r_q.hold_lo;
                        r_d.hold_vld = 1'b0;
                    end else begin
                        r_d.data = lo_byte;
                    end
                end
                SEL_BYTE: r_d.data = ten_i[ch_i] ? top_byte : lo_byte;
                SEL_STAT: r_d.data = BYTE_W'(done_i);
                default:  r_d.data = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '{data: '0, valid: 1'b0, kind: SEL_NONE,
                     hold_lo: '0, hold_ch: '0, hold_vld: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign rd_data_o  = r_q.data;
    assign rd_valid_o = r_q.valid;

    assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en_i |=> rd_valid_o);

    assert_valid_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en_i |=> !rd_valid_o);

    assert_hi_upper_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid_o && r_q.kind == SEL_HI) |-> (rd_data_o[BYTE_W-1:HI_W] == '0));

    assert_unmapped_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid_o && r_q.kind == SEL_NONE) |-> (rd_data_o == '0));

endmodule

// File: rtl/adc_result_bank.sv
module adc_result_bank
    import adc_rb_pkg::*;
#(
    parameter int NUM_CH = 8,
    parameter int RES_W  = 10,
    parameter int BYTE_W = 8
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 ten_mode_i,
    input  logic                                 irq_en_i,
    input  logic                                 wr_valid_i,
    input  logic [$clog2(NUM_CH)-1:0]            wr_ch_i,
    input  logic [RES_W-1:0]                     wr_code_i,
    input  logic                                 wr_ten_i,
    input  logic                                 rd_en_i,
    input  logic [$clog2(2*NUM_CH+1)-1:0]        rd_addr_i,
    output logic [BYTE_W-1:0]                    rd_data_o,
    output logic                                 rd_valid_o,
    output logic                                 irq_o
);

    localparam int CH_W   = $clog2(NUM_CH);
    localparam int ADDR_W = $clog2(2 * NUM_CH + 1);

    sel_kind_e                    kind;
    logic [CH_W-1:0]              sel_ch;
    logic                         clr;
    logic [NUM_CH-1:0][RES_W-1:0] codes;
    logic [NUM_CH-1:0]            tens;
    logic [NUM_CH-1:0]            dones;

    rb_addr_decode #(
        .NUM_CH (NUM_CH),
        .CH_W   (CH_W),
        .ADDR_W (ADDR_W)
    ) u_decode (
        .ten_mode_i (ten_mode_i),
        .addr_i     (rd_addr_i),
        .kind_o     (kind),
        .ch_o       (sel_ch)
    );

    // a flag clears when the channel's final byte is read
    assign clr = rd_en_i && (kind == SEL_LO || kind == SEL_BYTE);

    rb_result_store #(
        .NUM_CH (NUM_CH),
        .CH_W   (CH_W),
        .RES_W  (RES_W),
        .BYTE_W (BYTE_W)
    ) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_valid_i (wr_valid_i),
        .wr_ch_i    (wr_ch_i),
        .wr_code_i  (wr_code_i),
        .wr_ten_i   (wr_ten_i),
        .clr_i      (clr),
        .clr_ch_i   (sel_ch),
        .code_o     (codes),
        .ten_o      (tens),
        .done_o     (dones)
    );

    rb_readout #(
        .NUM_CH (NUM_CH),
        .CH_W   (CH_W),
        .RES_W  (RES_W),
        .BYTE_W (BYTE_W)
    ) u_readout (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_en_i    (rd_en_i),
        .kind_i     (kind),
        .ch_i       (sel_ch),
        .code_i     (codes),
        .ten_i      (tens),
        .done_i     (dones),
        .rd_data_o  (rd_data_o),
        .rd_valid_o (rd_valid_o)
    );

    assign irq_o = irq_en_i && (|dones);

    assert_irq_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> ($past(wr_valid_i) || $rose(irq_en_i)));

    assert_stat_keeps_flags_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_i && kind == SEL_STAT && !wr_valid_i) |=> $stable(dones));

endmodule

// File: tb/adc_result_bank_bench.sv
module adc_result_bank_bench;

    localparam int CLK_P = 10;
    localparam int NV    = 26;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ten_mode_i = 1'b1;
    logic       irq_en_i = 1'b0;
    logic       wr_valid_i = 1'b0;
    logic [2:0] wr_ch_i = '0;
    logic [9:0] wr_code_i = '0;
    logic       wr_ten_i = 1'b0;
    logic       rd_en_i = 1'b0;
    logic [4:0] rd_addr_i = '0;
    logic [7:0] rd_data_o;
    logic       rd_valid_o;
    logic       irq_o;

    int checks = 0;
    int errs = 0;
    bit finished = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    adc_result_bank u_adc_result_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .ten_mode_i (ten_mode_i),
        .irq_en_i   (irq_en_i),
        .wr_valid_i (wr_valid_i),
        .wr_ch_i    (wr_ch_i),
        .wr_code_i  (wr_code_i),
        .wr_ten_i   (wr_ten_i),
        .rd_en_i    (rd_en_i),
        .rd_addr_i  (rd_addr_i),
        .rd_data_o  (rd_data_o),
        .rd_valid_o (rd_valid_o),
        .irq_o      (irq_o)
    );

    // {req id, layout, address, expected byte}
    localparam logic [17:0] VEC [NV] = '{
        {4'd3, 1'b1, 5'd0,  8'h03}, {4'd3, 1'b1, 5'd1,  8'hA5},
        {4'd3, 1'b1, 5'd2,  8'h01}, {4'd3, 1'b1, 5'd3,  8'h55},
        {4'd3, 1'b1, 5'd4,  8'h02}, {4'd3, 1'b1, 5'd5,  8'hC3},
        {4'd3, 1'b1, 5'd6,  8'h00}, {4'd3, 1'b1, 5'd7,  8'h01},
        {4'd3, 1'b1, 5'd8,  8'h03}, {4'd3, 1'b1, 5'd9,  8'hFF},
        {4'd3, 1'b1, 5'd10, 8'h02}, {4'd3, 1'b1, 5'd11, 8'h00},
        {4'd5, 1'b1, 5'd12, 8'h00}, {4'd5, 1'b1, 5'd13, 8'h7E},
        {4'd5, 1'b1, 5'd14, 8'h00}, {4'd5, 1'b1, 5'd15, 8'h81},
        {4'd11, 1'b1, 5'd17, 8'h00},
        {4'd4, 1'b0, 5'd0,  8'hE9}, {4'd4, 1'b0, 5'd1,  8'h55},
        {4'd4, 1'b0, 5'd2,  8'hB0}, {4'd4, 1'b0, 5'd3,  8'h00},
        {4'd4, 1'b0, 5'd4,  8'hFF}, {4'd4, 1'b0, 5'd5,  8'h80},
        {4'd4, 1'b0, 5'd6,  8'h7E}, {4'd4, 1'b0, 5'd7,  8'h81},
        {4'd11, 1'b0, 5'd9, 8'h00}
    };

    function automatic string tag_of(input logic [3:0] id);
        case (id)
            4'd3:    return "R3";
            4'd4:    return "R4";
            4'd5:    return "R5";
            default: return "R11";
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic put(input logic [2:0] ch, input logic [9:0] code, input logic ten);
        @(negedge clk);
        wr_valid_i = 1'b1; wr_ch_i = ch; wr_code_i = code; wr_ten_i = ten;
        @(negedge clk);
        wr_valid_i = 1'b0;
    endtask

    task automatic get(input logic mode, input logic [4:0] addr, output logic [7:0] d);
        @(negedge clk);
        ten_mode_i = mode; rd_en_i = 1'b1; rd_addr_i = addr;
        @(negedge clk);
        rd_en_i = 1'b0;
        d = rd_data_o;
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errs);
    endtask

    initial begin
        #(CLK_P * 150000);
        if (!finished) begin
            checks++; errs++;
            $display("FAIL watchdog: actual hung expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        repeat (3) @(negedge clk);
        // R1 during reset
        check("R1 data", 32'(rd_data_o), 32'h0);
        check("R1 valid", 32'(rd_valid_o), 32'h0);
        check("R1 irq", 32'(irq_o), 32'h0);
        rst_n = 1'b1;
        irq_en_i = 1'b1;
        @(negedge clk);
        check("R1 irq after", 32'(irq_o), 32'h0);
        get(1'b1, 5'd16, d);
        check("R1 status", 32'(d), 32'h0);

        // R2 read timing
        @(negedge clk);
        rd_en_i = 1'b1; rd_addr_i = 5'd16;
        @(negedge clk);
        rd_en_i = 1'b0;
        check("R2 valid high", 32'(rd_valid_o), 32'h1);
        @(negedge clk);
        check("R2 valid low", 32'(rd_valid_o), 32'h0);

        // load results
        irq_en_i = 1'b0;
        put(3'd0, 10'h3A5, 1'b1);
        check("R10 irq gated", 32'(irq_o), 32'h0);
        irq_en_i = 1'b1;
        @(negedge clk);
        check("R10 irq level", 32'(irq_o), 32'h1);
        put(3'd1, 10'h155, 1'b1);
        put(3'd2, 10'h2C3, 1'b1);
        put(3'd3, 10'h001, 1'b1);
        put(3'd4, 10'h3FF, 1'b1);
        put(3'd5, 10'h200, 1'b1);
        put(3'd6, 10'h37E, 1'b0);
        put(3'd7, 10'h081, 1'b0);

        get(1'b1, 5'd16, d);
        check("R6 status all", 32'(d), 32'hFF);
        get(1'b0, 5'd16, d);
        check("R6 status 8-bit layout, not cleared", 32'(d), 32'hFF);
        get(1'b1, 5'd0, d);
        check("R7 hi read", 32'(d), 32'h03);
        get(1'b1, 5'd16, d);
        check("R7 hi keeps flag", 32'(d), 32'hFF);

        for (int i = 0; i < NV; i++) begin
            get(VEC[i][13], VEC[i][12:8], d);
            check(tag_of(VEC[i][17:14]), 32'(d), 32'(VEC[i][7:0]));
        end

        get(1'b1, 5'd16, d);
        check("R7 all cleared", 32'(d), 32'h00);
        check("R10 irq drop", 32'(irq_o), 32'h0);

        // R8 coincident write and low read of channel 2
        @(negedge clk);
        ten_mode_i = 1'b1; rd_en_i = 1'b1; rd_addr_i = 5'd5;
        wr_valid_i = 1'b1; wr_ch_i = 3'd2; wr_code_i = 10'h111; wr_ten_i = 1'b1;
        @(negedge clk);
        rd_en_i = 1'b0; wr_valid_i = 1'b0;
        check("R8 old value", 32'(rd_data_o), 32'hC3);
        get(1'b1, 5'd16, d);
        check("R8 flag set", 32'(d), 32'h04);
        get(1'b1, 5'd5, d);
        check("R8 new value", 32'(d), 32'h11);

        // R9 pair capture
        put(3'd3, 10'h2AB, 1'b1);
        get(1'b1, 5'd6, d);
        check("R9 hi", 32'(d), 32'h02);
        put(3'd3, 10'h1CD, 1'b1);
        get(1'b1, 5'd7, d);
        check("R9 captured lo", 32'(d), 32'hAB);
        get(1'b1, 5'd6, d);
        check("R9 new hi", 32'(d), 32'h01);
        get(1'b1, 5'd7, d);
        check("R9 new lo", 32'(d), 32'hCD);
        get(1'b1, 5'd7, d);
        check("R9 capture used once", 32'(d), 32'hCD);

        finished = 1'b1;
        summary();
        $finish;
    end

endmodule